// File: doc/BRIEF.md
# Serial-Bus Byte Memory Slave

This block is the target side of a byte-wide nonvolatile-style memory that a host reaches over a four-wire SPI link. The memory holds 8,192 bytes. A frame opens when the select line falls. An opcode byte comes first. Depending on the opcode, a 16-bit address follows and then a stream of data bytes, or a single status byte. The block turns the serial bits into opcodes, addresses and data bytes. It keeps an address pointer that steps after each byte, so one frame can move a run of bytes. It shifts read data and status back to the host.

All logic runs on a fast on-chip clock. The serial clock, select, data, pause and protect pins are brought into that clock domain through synchronizers, and the serial clock edges are detected there. Because of this, the serial clock may idle low (mode 0) or high (mode 3) and the block works the same way.

A pause input lets the host freeze a frame without deselecting. A status bit works together with a protect pin to lock the status register against writes.

Top module: `spi_fram_slave`

## Requirements
- R1: After reset the output enable is low, and a status read returns 0x00. In the status byte, bit 7 is the protect-enable flag, bit 1 is the write latch, and all other bits read 0.
- R2: While select is high, the output enable is low and clock and data activity changes neither the memory nor the status. While select is low and pause is high, the output enable is high.
- R3: Input bits are taken on rising serial-clock edges and output bits change on falling edges, MSB first. This holds both when the clock idles low and when it idles high.
- R4: Opcode 0x06 sets the write latch and opcode 0x04 clears it. The latch also clears when select rises after an accepted 0x02 or 0x01 frame.
- R5: Opcode 0x02 followed by a 16-bit address writes the following data bytes, and the upper 3 address bits are ignored. The write takes place only when the write latch is set; otherwise the memory is left unchanged.
- R6: Opcode 0x03 followed by a 16-bit address returns the stored byte at that address.
- R7: The address pointer steps by one after every data byte in a read or write frame, and it wraps from 0x1FFF to 0x0000.
- R8: A data byte is stored only once all 8 of its bits have arrived. A partial byte cut off by select rising is discarded.
- R9: Opcode 0x01 loads the protect-enable flag from bit 7 of the next byte, but only when the write latch is set. The write is refused when the protect pin is low and the flag is already set.
- R10: While pause is low and select is low, the output enable is low and clock and data are ignored. Raising pause resumes the frame at the bit where it stopped.
- R11: Opcode 0x05 returns the status byte, and keeps repeating it while the host keeps clocking.
- R12: Any other opcode makes the rest of the frame have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | On-chip clock that samples all pins |
| rst_n | input | 1 | Asynchronous reset, active low |
| ssel_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| pause_n | input | 1 | Freezes the frame when low |
| wprot_n | input | 1 | Status write protect pin, active low |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for the tri-state driver of miso |

## Verification
The hardest case to reach is a pause that lands in the middle of a read byte while the host keeps moving the clock and data lines. Only a correct design loses no bit and gains no bit in that case. The bench starts a read at the end of a wrapped burst and stops after three bits of the first data byte. It drives the pause low and toggles the clock several times with data high. It then restores the clock level and releases the pause. Finally it checks that this byte and the next one both come out intact. The protect lock is reached the same way: first set the flag, then pull the protect pin low, then attempt a write.

// File: rtl/spi_fram_pkg.sv
`timescale 1ns/1ps
package spi_fram_pkg;

    localparam logic [7:0] OP_WR_ENA  = 8'h06;
    localparam logic [7:0] OP_WR_DIS  = 8'h04;
    localparam logic [7:0] OP_STAT_RD = 8'h05;
    localparam logic [7:0] OP_STAT_WR = 8'h01;
    localparam logic [7:0] OP_MEM_RD  = 8'h03;
    localparam logic [7:0] OP_MEM_WR  = 8'h02;

    localparam int SR_PROT_BIT = 7;
    localparam int SR_WEL_BIT  = 1;

    localparam int ADDR_BITS_ON_WIRE = 16;

    typedef enum logic [2:0] {
        ST_OPCODE,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_STAT_OUT,
        ST_STAT_IN,
        ST_DRAIN
    } frame_st_e;

endpackage

// File: rtl/spi_pin_sync.sv
`timescale 1ns/1ps
module spi_pin_sync #(
    parameter int          W       = 5,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] pin_s
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q;
        logic sync_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[g];
                sync_q <= RST_VAL[g];
            end else begin
                meta_q <= pin_i[g];
                sync_q <= meta_q;
            end
        end
        assign pin_s[g] = sync_q;
    end
endmodule

// File: rtl/spi_byte_array.sv
`timescale 1ns/1ps
module spi_byte_array #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cell_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cell_q[waddr] <= wdata;
        end
    end

    assign rdata = cell_q[raddr];
endmodule

// File: rtl/spi_frame_ctrl.sv
`timescale 1ns/1ps
module spi_frame_ctrl
    import spi_fram_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ssel_s,
    input  logic              pause_s,
    input  logic              wprot_s,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [7:0]        mem_wdata,
    output logic              miso,
    output logic              miso_oe,
    output logic              wr_latch,
    output logic              prot_en
);
    localparam int SH_W    = (ADDR_W > 8) ? ADDR_W : 8;
    localparam int CNT_W   = $clog2(ADDR_BITS_ON_WIRE);
    localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(7);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_BITS_ON_WIRE - 1);

    typedef struct packed {
        frame_st_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [SH_W-2:0]   rx;
        logic [7:0]        opc;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        tx;
        logic              so;
        logic              oe;
        logic              wel;
        logic              prot;
        logic              clr_wel;
        logic              sclk_p;
    } ctrl_t;

    ctrl_t ctl_q, ctl_d;

    logic            rise_d, fall_d, live_d;
    logic [SH_W-1:0] shin_d;
    logic [7:0]      byte_d;
    logic [7:0]      stat_d;
    logic [7:0]      src_d;
    logic            we_d;
    logic [ADDR_W-1:0] waddr_d;

    always_comb begin
        ctl_d   = ctl_q;
        we_d    = 1'b0;
        waddr_d = ctl_q.addr;

        rise_d = sclk_s & ~ctl_q.sclk_p;
        fall_d = ~sclk_s & ctl_q.sclk_p;
        live_d = ~ssel_s & pause_s;
        shin_d = {ctl_q.rx, mosi_s};
        byte_d = shin_d[7:0];

        stat_d = '0;
        stat_d[SR_PROT_BIT] = ctl_q.prot;
        stat_d[SR_WEL_BIT]  = ctl_q.wel;
        src_d  = (ctl_q.st == ST_RDATA) ? rd_data : stat_d;

        ctl_d.sclk_p = sclk_s;
        ctl_d.oe     = live_d;

        if (ssel_s) begin
            ctl_d.st      = ST_OPCODE;
            ctl_d.cnt     = '0;
            ctl_d.clr_wel = 1'b0;
            if (ctl_q.clr_wel) begin
                ctl_d.wel = 1'b0;
            end
        end else if (live_d && rise_d) begin
            ctl_d.rx  = shin_d[SH_W-2:0];
            ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
            unique case (ctl_q.st)
                ST_OPCODE: begin
                    if (ctl_q.cnt == BYTE_LAST) begin
                        ctl_d.cnt = '0;
                        ctl_d.opc = byte_d;
                        ctl_d.st  = ST_DRAIN;
                        if (byte_d == OP_WR_ENA) begin
                            ctl_d.wel = 1'b1;
                        end else if (byte_d == OP_WR_DIS) begin
                            ctl_d.wel = 1'b0;
                        end else if (byte_d == OP_STAT_RD) begin
                            ctl_d.st = ST_STAT_OUT;
                        end else if (byte_d == OP_STAT_WR && ctl_q.wel) begin
                            ctl_d.st      = ST_STAT_IN;
                            ctl_d.clr_wel = 1'b1;
                        end else if (byte_d == OP_MEM_RD) begin
                            ctl_d.st = ST_ADDR;
                        end else if (byte_d == OP_MEM_WR && ctl_q.wel) begin
                            ctl_d.st      = ST_ADDR;
                            ctl_d.clr_wel = 1'b1;
                        end
                    end
                end
                ST_ADDR: begin
                    if (ctl_q.cnt == ADDR_LAST) begin
                        ctl_d.cnt  = '0;
                        ctl_d.addr = shin_d[ADDR_W-1:0];
                        ctl_d.st   = (ctl_q.opc == OP_MEM_RD) ? ST_RDATA : ST_WDATA;
                    end
                end
                ST_WDATA: begin
                    if (ctl_q.cnt == BYTE_LAST) begin
                        ctl_d.cnt  = '0;
                        we_d       = 1'b1;
                        ctl_d.addr = ctl_q.addr + ADDR_W'(1);
                    end
                end
                ST_RDATA: begin
                    if (ctl_q.cnt == BYTE_LAST) begin
                        ctl_d.cnt  = '0;
                        ctl_d.addr = ctl_q.addr + ADDR_W'(1);
                    end
                end
                ST_STAT_OUT: begin
                    if (ctl_q.cnt == BYTE_LAST) begin
                        ctl_d.cnt = '0;
                    end
                end
                ST_STAT_IN: begin
                    if (ctl_q.cnt == BYTE_LAST) begin
                        ctl_d.cnt = '0;
                        ctl_d.st  = ST_DRAIN;
                        if (wprot_s || !ctl_q.prot) begin
                            ctl_d.prot = byte_d[SR_PROT_BIT];
                        end
                    end
                end
                default: begin
                    ctl_d.cnt = '0;
                end
            endcase
        end else if (live_d && fall_d) begin
            if (ctl_q.st == ST_RDATA || ctl_q.st == ST_STAT_OUT) begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.so = src_d[7];
                    ctl_d.tx = {src_d[6:0], 1'b0};
                end else begin
                    ctl_d.so = ctl_q.tx[7];
                    ctl_d.tx = {ctl_q.tx[6:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q         <= '0;
            ctl_q.st      <= ST_OPCODE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cur_addr  = ctl_q.addr;
    assign mem_we    = we_d;
    assign mem_waddr = waddr_d;
    assign mem_wdata = byte_d;
    assign miso      = ctl_q.so;
    assign miso_oe   = ctl_q.oe;
    assign wr_latch  = ctl_q.wel;
    assign prot_en   = ctl_q.prot;
endmodule

// File: rtl/spi_fram_slave.sv
`timescale 1ns/1ps
module spi_fram_slave #(
    parameter int ADDR_W = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ssel_n,
    input  logic sclk,
    input  logic mosi,
    input  logic pause_n,
    input  logic wprot_n,
    output logic miso,
    output logic miso_oe
);
    localparam int        PIN_N   = 5;
    localparam logic [PIN_N-1:0] PIN_RST = 5'b11100;

    logic [PIN_N-1:0] pin_s;
    logic             ssel_s, pause_s, wprot_s, sclk_s, mosi_s;
    logic [ADDR_W-1:0] cur_addr;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [7:0]        mem_wdata;
    logic [7:0]        rd_data;
    logic              wr_latch;
    logic              prot_en;

    spi_pin_sync #(
        .W       (PIN_N),
        .RST_VAL (PIN_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({ssel_n, pause_n, wprot_n, sclk, mosi}),
        .pin_s (pin_s)
    );

    assign ssel_s  = pin_s[4];
    assign pause_s = pin_s[3];
    assign wprot_s = pin_s[2];
    assign sclk_s  = pin_s[1];
    assign mosi_s  = pin_s[0];

    spi_frame_ctrl #(
        .ADDR_W (ADDR_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ssel_s    (ssel_s),
        .pause_s   (pause_s),
        .wprot_s   (wprot_s),
        .sclk_s    (sclk_s),
        .mosi_s    (mosi_s),
        .rd_data   (rd_data),
        .cur_addr  (cur_addr),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .miso      (miso),
        .miso_oe   (miso_oe),
        .wr_latch  (wr_latch),
        .prot_en   (prot_en)
    );

    spi_byte_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (8)
    ) u_array (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (cur_addr),
        .rdata (rd_data)
    );
endmodule

// File: rtl/spi_fram_slave_chk.sv
`timescale 1ns/1ps
module spi_fram_slave_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ssel_s,
    input logic              pause_s,
    input logic              wprot_s,
    input logic              miso_oe,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_waddr,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              wr_latch,
    input logic              prot_en
);
    // R2
    standby_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ssel_s |-> !mem_we);

    // R2
    standby_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ssel_s |=> !miso_oe);

    // R10
    pause_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ssel_s && !pause_s) |=> ($stable(cur_addr) && !miso_oe && !mem_we));

    // R5
    write_needs_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wr_latch);

    // R7
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (cur_addr == $past(mem_waddr) + ADDR_W'(1)));

    // R9
    prot_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_en != $past(prot_en)) |-> ($past(wr_latch) && ($past(wprot_s) || !$past(prot_en))));

    // R4
    latch_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_latch) |-> !$past(ssel_s));
endmodule

bind spi_fram_slave spi_fram_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ssel_s    (ssel_s),
    .pause_s   (pause_s),
    .wprot_s   (wprot_s),
    .miso_oe   (miso_oe),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .cur_addr  (cur_addr),
    .wr_latch  (wr_latch),
    .prot_en   (prot_en)
);

// File: tb/tb_spi_fram_slave.sv
`timescale 1ns/1ps
module tb_spi_fram_slave;
    localparam int HALF = 6;

    // {mode3, wire address, data}
    localparam logic [24:0] VEC [6] = '{
        {1'b0, 16'h0010, 8'hA5},
        {1'b1, 16'hE123, 8'h3C},
        {1'b0, 16'h1FFF, 8'hFF},
        {1'b1, 16'h0000, 8'h00},
        {1'b0, 16'h6AAA, 8'h96},
        {1'b1, 16'h1555, 8'h69}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ssel_n = 1'b1;
    logic sclk = 1'b0;
    logic mosi = 1'b0;
    logic pause_n = 1'b1;
    logic wprot_n = 1'b1;
    logic miso;
    logic miso_oe;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;
    bit  mode3  = 1'b0;
    logic [7:0] r0, r1, r2, r3;

    always #2.5 clk = ~clk;

    spi_fram_slave dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .ssel_n  (ssel_n),
        .sclk    (sclk),
        .mosi    (mosi),
        .pause_n (pause_n),
        .wprot_n (wprot_n),
        .miso    (miso),
        .miso_oe (miso_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic sel();
        sclk = mode3;
        tick(2);
        ssel_n = 1'b0;
        tick(HALF);
    endtask

    task automatic desel();
        if (!mode3) sclk = 1'b0;
        tick(HALF);
        ssel_n = 1'b1;
        tick(HALF);
    endtask

    task automatic send_bit(input logic b, output logic r);
        sclk = 1'b0;
        mosi = b;
        tick(HALF);
        r = miso;
        sclk = 1'b1;
        tick(HALF);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            send_bit(tx[i], b);
            rx[i] = b;
        end
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] d;
        sel();
        xfer(op, d);
        desel();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] d;
        sel();
        xfer(8'h05, d);
        xfer(8'h00, s);
        desel();
    endtask

    task automatic write1(input logic [15:0] a, input logic [7:0] v);
        logic [7:0] d;
        cmd1(8'h06);
        sel();
        xfer(8'h02, d);
        xfer(a[15:8], d);
        xfer(a[7:0], d);
        xfer(v, d);
        desel();
    endtask

    task automatic read1(input logic [15:0] a, output logic [7:0] v);
        logic [7:0] d;
        sel();
        xfer(8'h03, d);
        xfer(a[15:8], d);
        xfer(a[7:0], d);
        xfer(8'h00, v);
        desel();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1 reset state
        chk("R1 oe after reset", {7'd0, miso_oe}, 8'h00);
        rdsr(r0);
        chk("R1 status after reset", r0, 8'h00);

        // R4 / R11 latch set, status repeats
        cmd1(8'h06);
        sel();
        xfer(8'h05, d);
        chk("R2 oe while selected", {7'd0, miso_oe}, 8'h01);
        xfer(8'h00, r0);
        xfer(8'h00, r1);
        desel();
        chk("R4 latch set by 0x06", r0, 8'h02);
        chk("R11 status repeats", r1, 8'h02);
        cmd1(8'h04);
        rdsr(r0);
        chk("R4 latch cleared by 0x04", r0, 8'h00);

        // R3 R5 R6 vector table, both clock polarities
        foreach (VEC[k]) begin
            mode3 = VEC[k][24];
            write1(VEC[k][23:8], VEC[k][7:0]);
            read1(VEC[k][23:8] & 16'h1FFF, r0);
            chk(mode3 ? "R3 mode3 write/read" : "R6 mode0 write/read", r0, VEC[k][7:0]);
        end
        mode3 = 1'b0;
        rdsr(r0);
        chk("R4 latch cleared after write frame", r0, 8'h00);

        // R5 write without latch
        write1(16'h0100, 8'h11);
        sel();
        xfer(8'h02, d); xfer(8'h01, d); xfer(8'h00, d); xfer(8'h99, d);
        desel();
        read1(16'h0100, r0);
        chk("R5 write ignored without latch", r0, 8'h11);

        // R7 burst across wrap
        cmd1(8'h06);
        sel();
        xfer(8'h02, d); xfer(8'h1F, d); xfer(8'hFE, d);
        xfer(8'h01, d); xfer(8'h02, d); xfer(8'h03, d); xfer(8'h04, d);
        desel();
        sel();
        xfer(8'h03, d); xfer(8'h1F, d); xfer(8'hFE, d);
        xfer(8'h00, r0); xfer(8'h00, r1); xfer(8'h00, r2); xfer(8'h00, r3);
        desel();
        chk("R7 burst byte0", r0, 8'h01);
        chk("R7 burst byte1", r1, 8'h02);
        chk("R7 wrap byte2", r2, 8'h03);
        chk("R7 wrap byte3", r3, 8'h04);

        // R8 partial byte discarded
        write1(16'h0201, 8'h33);
        cmd1(8'h06);
        sel();
        xfer(8'h02, d); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h5A, d);
        for (int i = 7; i >= 4; i--) begin
            logic b;
            send_bit(1'b1, b);
        end
        desel();
        read1(16'h0200, r0);
        read1(16'h0201, r1);
        chk("R8 full byte kept", r0, 8'h5A);
        chk("R8 partial byte dropped", r1, 8'h33);

        // R10 pause mid-byte during read
        sel();
        xfer(8'h03, d); xfer(8'h1F, d); xfer(8'hFE, d);
        for (int i = 7; i >= 5; i--) begin
            logic b;
            send_bit(1'b0, b);
            r0[i] = b;
        end
        pause_n = 1'b0;
        tick(HALF);
        chk("R10 oe low while paused", {7'd0, miso_oe}, 8'h00);
        repeat (3) begin
            sclk = 1'b0; mosi = 1'b1; tick(HALF);
            sclk = 1'b1; tick(HALF);
        end
        pause_n = 1'b1;
        tick(HALF);
        chk("R10 oe back after pause", {7'd0, miso_oe}, 8'h01);
        for (int i = 4; i >= 0; i--) begin
            logic b;
            send_bit(1'b0, b);
            r0[i] = b;
        end
        xfer(8'h00, r1);
        desel();
        chk("R10 byte intact across pause", r0, 8'h01);
        chk("R10 next byte after pause", r1, 8'h02);

        // R9 status write and protection
        sel(); xfer(8'h01, d); xfer(8'h80, d); desel();
        rdsr(r0);
        chk("R9 status write refused without latch", r0, 8'h00);
        cmd1(8'h06);
        sel(); xfer(8'h01, d); xfer(8'h80, d); desel();
        rdsr(r0);
        chk("R9 flag set, latch cleared", r0, 8'h80);
        wprot_n = 1'b0;
        cmd1(8'h06);
        sel(); xfer(8'h01, d); xfer(8'h00, d); desel();
        rdsr(r0);
        chk("R9 locked by pin and flag", r0, 8'h80);
        wprot_n = 1'b1;
        cmd1(8'h06);
        sel(); xfer(8'h01, d); xfer(8'h00, d); desel();
        rdsr(r0);
        chk("R9 unlocked with pin high", r0, 8'h00);

        // R2 standby ignores activity
        tick(HALF);
        for (int i = 7; i >= 0; i--) begin
            mosi = OP_BITS(i);
            sclk = 1'b0; tick(HALF);
            sclk = 1'b1; tick(HALF);
        end
        chk("R2 oe low in standby", {7'd0, miso_oe}, 8'h00);
        sclk = 1'b0;
        rdsr(r0);
        chk("R2 standby clocks ignored", r0, 8'h00);

        // R12 unknown opcode
        cmd1(8'h06);
        sel(); xfer(8'hAB, d); xfer(8'h04, d); xfer(8'h02, d); desel();
        rdsr(r0);
        chk("R12 unknown opcode no effect", r0, 8'h02);
        cmd1(8'h04);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    function automatic logic OP_BITS(input int i);
        logic [7:0] wren = 8'h06;
        return wren[i];
    endfunction
endmodule